// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a management-bus master that carries IEEE 802.3 register transactions from a host register interface to external PHYs over a clock line (MDC) and a bidirectional data line. The data line is given as a driven value, an output enable and a sampled input, and a pad at the chip edge combines them. One engine builds both Clause 22 and Clause 45 frames. A mode bit in the configuration register chooses the framing.

Software configures the MDC divider, the framing mode and preamble suppression, then programs the port and device fields. A frame starts as a side effect of a register write. An address-register write in Clause 45 mode sends an address frame. A data-register write sends a write frame. A control write with the start-read bit set sends a read frame. Software polls the busy flag. After a read it collects the returned 16 bits from the data register and checks the read-error flag, which reports a PHY that failed to pull the turnaround low.

Top module: `mdio_master`

## Requirements
- R1: After reset, the configuration/status word (byte offset 0x30) reads 0x0000_0280: divider field = 5, and busy, read error, preamble-off and Clause 45 bits all 0. Control (0x34), data (0x38) and address (0x3C) read 0. MDC is low and the output enable is low.
- R2: The configuration/status word holds busy at bit 0, read error at bit 1, preamble-off at bit 5, Clause 45 select at bit 6 and the divider in bits 15:7. The control word holds the device (or Clause 22 register) number in bits 4:0, the port number in bits 9:5 and the increment flag in bit 14. The start-read bit 15 always reads as 0. Data and address keep their low 16 bits. Any other offset reads 0, and writes to it change nothing.
- R3: While a frame runs, each bit takes 2·div+1 input clocks. MDC is low for the first div+1 of those clocks and high for the remaining div. Busy stays set for exactly (frame bits)·(2·div+1) clocks. MDC is low whenever busy is clear.
- R4: In Clause 22 mode, a data write sends 32 ones, start 01, opcode 01, the 5-bit port, the 5-bit register, turnaround 10 and the 16 data bits, most significant bit first.
- R5: A control write with bit 15 set sends a read frame (Clause 22: start 01, opcode 10). The output enable drops from the first turnaround bit to the end of the frame. The 16 bits sampled on the MDC rising edges of the data phase then appear in data bits 15:0, with bits 31:16 at 0.
- R6: In Clause 45 mode the start field is 00. An address write sends opcode 00 with the address as payload. A data write sends opcode 01. A read sends opcode 11. In Clause 22 mode an address write only stores the value and starts no frame.
- R7: If the PHY leaves the second turnaround bit high during a read, status bit 1 is set. Bit 1 is cleared when the next read frame starts.
- R8: With preamble-off set, the frame omits the 32 leading ones and is 32 bits long.
- R9: Writes to the status, control, data or address registers while busy is set are ignored. They start no frame and change no stored field.
- R10: A status write whose divider field is below 5 leaves the divider unchanged. Values from 5 up to 511 are taken.
- R11: The master changes the driven data value and its enable only while MDC is low, never across a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that MDC is divided from |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W (6) | Byte offset of the register accessed |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational, no side effects) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line (0 = released) |
| mdio_i | input | 1 | Value sampled from the data line |

## Verification
A model PHY records every bit on MDC rising edges together with the enable. It also plays back a prepared reply for read frames. Each frame is compared bit by bit against a frame the bench builds, with the enable checked against the expected drive mask. Randomly drawn transactions cover all five frame kinds, preamble on and off, and several divider values. Because the bit timing, the start and opcode fields and the release point all differ across these cases, a wrong opcode table, a wrong preamble length, an off-by-one divider or a late release each produce a different mismatch. Directed cases cover an illegal divider, a Clause 22 address write, a bad turnaround followed by a clean read, and a burst of writes made while busy.

// File: rtl/mdio_pkg.sv
// Package for the MDIO master: register offsets, frame geometry and the
// frame builder shared by the register file and the shifter.
// Assumes a 64-bit frame image: 32 preamble ones then 32 frame bits.
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int PAYLOAD_W  = 16;
    localparam int TA_POS     = 46;   // first turnaround bit position
    localparam int RX_POS     = 48;   // first read data bit position
    localparam int DIV_MIN    = 5;

    localparam logic [7:0] OFS_STAT = 8'h30;
    localparam logic [7:0] OFS_CTRL = 8'h34;
    localparam logic [7:0] OFS_DATA = 8'h38;
    localparam logic [7:0] OFS_ADDR = 8'h3C;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_t;

    // Build the full 64-bit frame image, transmitted MSB first.
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic                 c45,
        input frame_kind_t          kind,
        input logic [4:0]           port,
        input logic [4:0]           dev,
        input logic [PAYLOAD_W-1:0] payload
    );
        logic [1:0] st;
        logic [1:0] op;
        logic [1:0] ta;
        logic [PAYLOAD_W-1:0] pl;
        st = c45 ? 2'b00 : 2'b01;
        ta = 2'b10;
        pl = payload;
        unique case (kind)
            FK_ADDR:  op = 2'b00;
            FK_WRITE: op = 2'b01;
            default: begin
                op = c45 ? 2'b11 : 2'b10;
                ta = 2'b11;
                pl = '1;
            end
        endcase
        return {{PRE_BITS{1'b1}}, st, op, port, dev, ta, pl};
    endfunction

endpackage

// File: rtl/mdio_regs.sv
// Register file of the MDIO master. Holds configuration, control, data and
// address words, decodes launching writes and returns read data.
// Assumes at most one bus write per cycle; all writes are dropped while busy.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DIV_W     = 9,
    parameter int DIV_RESET = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  busy,
    input  logic                  rd_err,
    input  logic                  done_rd,
    input  logic [PAYLOAD_W-1:0]  rx_data,
    output logic                  launch,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  frame_rd,
    output logic                  pre_dis,
    output logic [DIV_W-1:0]      div
);

    localparam int DIV_LSB = 7;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFS_ADDR);

    logic                 c45_q;
    logic [4:0]           dev_q;
    logic [4:0]           port_q;
    logic                 pinc_q;
    logic [PAYLOAD_W-1:0] data_q;
    logic [PAYLOAD_W-1:0] addr_q;
    logic [DIV_W-1:0]     wr_div;
    logic wr_stat, wr_ctrl, wr_data, wr_addr;
    logic unused_wdata;

    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_addr = bus_wr && (bus_addr == A_ADDR);
    assign wr_div  = bus_wdata[DIV_LSB +: DIV_W];
    assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[13:10]};

    // Store configuration and operands; load read result at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45_q   <= 1'b0;
            pre_dis <= 1'b0;
            div     <= DIV_W'(DIV_RESET);
            dev_q   <= '0;
            port_q  <= '0;
            pinc_q  <= 1'b0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (!busy) begin
                if (wr_stat) begin
                    pre_dis <= bus_wdata[5];
                    c45_q   <= bus_wdata[6];
                    if (wr_div >= DIV_W'(DIV_MIN))
                        div <= wr_div;
                end
                if (wr_ctrl) begin
                    dev_q  <= bus_wdata[4:0];
                    port_q <= bus_wdata[9:5];
                    pinc_q <= bus_wdata[14];
                end
                if (wr_data) data_q <= bus_wdata[PAYLOAD_W-1:0];
                if (wr_addr) addr_q <= bus_wdata[PAYLOAD_W-1:0];
            end
            if (done_rd) data_q <= rx_data;
        end
    end

    // Decide whether this write starts a frame and build its image.
    always_comb begin
        launch   = 1'b0;
        frame_rd = 1'b0;
        frame    = make_frame(c45_q, FK_WRITE, port_q, dev_q, bus_wdata[PAYLOAD_W-1:0]);
        if (!busy) begin
            if (wr_ctrl && bus_wdata[15]) begin
                launch   = 1'b1;
                frame_rd = 1'b1;
                frame    = make_frame(c45_q, FK_READ, bus_wdata[9:5], bus_wdata[4:0], '0);
            end else if (wr_data) begin
                launch = 1'b1;
            end else if (wr_addr && c45_q) begin
                launch = 1'b1;
                frame  = make_frame(1'b1, FK_ADDR, port_q, dev_q, bus_wdata[PAYLOAD_W-1:0]);
            end
        end
    end

    // Side-effect-free read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT: begin
                bus_rdata[0] = busy;
                bus_rdata[1] = rd_err;
                bus_rdata[5] = pre_dis;
                bus_rdata[6] = c45_q;
                bus_rdata[DIV_LSB +: DIV_W] = div;
            end
            A_CTRL: bus_rdata = {17'd0, pinc_q, 4'd0, port_q, dev_q};
            A_DATA: bus_rdata = {16'd0, data_q};
            A_ADDR: bus_rdata = {16'd0, addr_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_clkgen.sv
// MDC generator. While run is high it produces one MDC period every
// 2*div+1 clocks: low for div+1 clocks, then high for div clocks.
// rise_tick marks the edge where MDC goes high, fall_tick the period end.
// Assumes div >= 1 and that run rises with the counter at zero.
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;

    assign rise_tick = run && (cnt == {1'b0, div});
    assign fall_tick = run && (cnt == {div, 1'b0});

    // Count clocks inside one MDC period and toggle MDC at the ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_tick) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_tick) mdc <= 1'b1;
        end
    end

endmodule

// File: rtl/mdio_shifter.sv
// Frame shifter. Walks the 64-bit frame image one bit per MDC period,
// drives the data line, releases it for the read turnaround and data,
// samples reply bits on MDC rising edges and flags a bad turnaround.
// Assumes mdio_i is already synchronous to clk.
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic [FRAME_BITS-1:0] frame_in,
    input  logic                  frame_rd,
    input  logic                  pre_dis,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  rd_err,
    output logic                  done_rd,
    output logic [PAYLOAD_W-1:0]  rx_data,
    output logic                  mdio_o,
    output logic                  mdio_oe
);

    localparam int POS_W = $clog2(FRAME_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] frame_q;
    logic [POS_W-1:0]      pos;
    logic                  is_rd;

    assign done_rd = busy && is_rd && fall_tick && (pos == POS_LAST);
    assign mdio_o  = busy ? frame_q[POS_LAST - pos] : 1'b1;
    assign mdio_oe = busy && !(is_rd && (pos >= POS_W'(TA_POS)));

    // Sequence the frame bits and collect the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_err  <= 1'b0;
            is_rd   <= 1'b0;
            pos     <= '0;
            frame_q <= '0;
            rx_data <= '0;
        end else if (launch) begin
            busy    <= 1'b1;
            is_rd   <= frame_rd;
            frame_q <= frame_in;
            pos     <= pre_dis ? POS_W'(PRE_BITS) : '0;
            rx_data <= '0;
            if (frame_rd) rd_err <= 1'b0;
        end else if (busy) begin
            if (rise_tick && is_rd) begin
                if (pos == POS_W'(TA_POS + 1)) rd_err <= mdio_i;
                if (pos >= POS_W'(RX_POS)) rx_data <= {rx_data[PAYLOAD_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (pos == POS_LAST) busy <= 1'b0;
                else pos <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
// Top of the MDIO management master: register file, MDC generator and
// frame shifter. The data line pad is outside: mdio_o/mdio_oe/mdio_i.
// Assumes the bus issues single-cycle write strobes and mdio_i is synchronous.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DIV_W     = 9,
    parameter int DIV_RESET = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic                  busy;
    logic                  rd_err;
    logic                  done_rd;
    logic [PAYLOAD_W-1:0]  rx_data;
    logic                  launch;
    logic [FRAME_BITS-1:0] frame;
    logic                  frame_rd;
    logic                  pre_dis;
    logic [DIV_W-1:0]      div;
    logic                  rise_tick;
    logic                  fall_tick;

    mdio_regs #(
        .ADDR_W   (ADDR_W),
        .DIV_W    (DIV_W),
        .DIV_RESET(DIV_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .rd_err   (rd_err),
        .done_rd  (done_rd),
        .rx_data  (rx_data),
        .launch   (launch),
        .frame    (frame),
        .frame_rd (frame_rd),
        .pre_dis  (pre_dis),
        .div      (div)
    );

    mdio_clkgen #(
        .DIV_W(DIV_W)
    ) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div      (div),
        .mdc      (mdc),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    mdio_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .frame_in (frame),
        .frame_rd (frame_rd),
        .pre_dis  (pre_dis),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .rd_err   (rd_err),
        .done_rd  (done_rd),
        .rx_data  (rx_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_master_chk.sv
// Property checker for mdio_master, attached through bind.
// Relates the busy flag, the launch decode and the line outputs.
module mdio_master_chk #(
    parameter int DIV_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             launch,
    input logic [DIV_W-1:0] div,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe
);

    // R3
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R3
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !mdc && mdio_oe));

    // R3
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!mdc && !mdio_oe));

    // R11
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R10
    div_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(5));

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .launch (launch),
    .div    (div),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h30;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model PHY: record line on MDC rise, then present the next reply bit.
    logic [63:0] resp = '1;
    logic [63:0] obs_o = '0;
    logic [63:0] obs_oe = '0;
    int phy_pos = 0;
    int rises = 0;
    always @(posedge mdc) begin
        if (phy_pos < 64) begin
            obs_o[63-phy_pos]  = mdio_o;
            obs_oe[63-phy_pos] = mdio_oe;
        end
        phy_pos++;
        rises++;
        mdio_i = (phy_pos < 64) ? resp[63-phy_pos] : 1'b1;
    end

    // R11 monitor: line must not move across an MDC high phase.
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
    int hold_viol = 0;
    always @(negedge clk) begin
        if (prev_mdc && mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) hold_viol++;
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h30;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 6'h30;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        #1;
        while (bus_rdata[0] === 1'b1 && cyc < 100000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] stat_word(input int div, input bit c45, input bit pre);
        return (32'(div) << 7) | (32'(c45) << 6) | (32'(pre) << 5);
    endfunction

    function automatic logic [63:0] exp_frame(input int kind, input bit c45,
            input logic [4:0] port, input logic [4:0] dev, input logic [15:0] d);
        logic [1:0] op;
        if (kind == 0)      op = 2'b00;
        else if (kind == 1) op = 2'b01;
        else                op = c45 ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, port, dev, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_oe(input bit is_read, input int start);
        logic [63:0] m = '0;
        for (int p = start; p < 64; p++)
            m[63-p] = !(is_read && p >= 46);
        return m;
    endfunction

    // kind: 0 = address, 1 = write, 2 = read
    task automatic txn(input int kind, input bit c45, input bit pre, input int div,
            input logic [4:0] port, input logic [4:0] dev, input logic [15:0] d,
            input logic [15:0] rdval, input bit tabad, input bit pinc);
        int cyc, nb, start;
        logic [31:0] v;
        logic [63:0] win, m, e;
        string tag;
        tag = (kind == 2) ? (c45 ? "R6/R5 read" : "R5 read") :
              (kind == 0) ? "R6 address" : (c45 ? "R6 write" : "R4 write");
        if (pre) tag = {tag, " R8"};
        start = pre ? 32 : 0;
        nb = 64 - start;
        wr(6'h30, stat_word(div, c45, pre));
        wr(6'h34, (32'(pinc) << 14) | (32'(port) << 5) | 32'(dev));
        resp = {46'h3FFF_FFFF_FFFF, 1'b1, tabad, rdval};
        obs_o = '0; obs_oe = '0; rises = 0; phy_pos = start;
        mdio_i = resp[63-start];
        if (kind == 0)      wr(6'h3C, 32'(d));
        else if (kind == 1) wr(6'h38, 32'(d));
        else wr(6'h34, 32'h8000 | (32'(pinc) << 14) | (32'(port) << 5) | 32'(dev));
        wait_idle(cyc);
        check("R3 busy length", 64'(cyc), 64'(nb * (2*div + 1)));
        check("R3 mdc periods", 64'(rises), 64'(nb));
        win = (start == 0) ? '1 : 64'h0000_0000_FFFF_FFFF;
        m = exp_oe(kind == 2, start);
        e = exp_frame(kind, c45, port, dev, d);
        check({tag, " enable"}, obs_oe & win, m);
        check({tag, " bits"}, obs_o & m, e & m);
        if (kind == 2) begin
            rd(6'h38, v);
            check("R5 read data", 64'(v), 64'({16'h0, rdval}));
            rd(6'h30, v);
            check("R7 read error flag", 64'(v[1]), 64'(tabad));
        end
        rd(6'h34, v);
        check("R2 control readback", 64'(v), 64'((32'(pinc) << 14) | (32'(port) << 5) | 32'(dev)));
    endtask

    initial begin
        logic [31:0] v;
        int cyc;
        void'($urandom(32'd715));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h30, v); check("R1 status reset", 64'(v), 64'h280);
        rd(6'h34, v); check("R1 control reset", 64'(v), 64'h0);
        rd(6'h38, v); check("R1 data reset", 64'(v), 64'h0);
        rd(6'h3C, v); check("R1 address reset", 64'(v), 64'h0);
        check("R1 line idle", {62'h0, mdc, mdio_oe}, 64'h0);

        // R2 unmapped offsets
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        rd(6'h00, v); check("R2 unmapped 0x00", 64'(v), 64'h0);
        rd(6'h2C, v); check("R2 unmapped 0x2C", 64'(v), 64'h0);
        rd(6'h30, v); check("R2 status after unmapped writes", 64'(v), 64'h280);

        // R10 divider limits
        wr(6'h30, stat_word(3, 0, 0)); rd(6'h30, v);
        check("R10 div 3 rejected", 64'(v), 64'(stat_word(5, 0, 0)));
        wr(6'h30, stat_word(4, 1, 1)); rd(6'h30, v);
        check("R10 div 4 rejected", 64'(v), 64'(stat_word(5, 1, 1)));
        wr(6'h30, stat_word(511, 0, 1)); rd(6'h30, v);
        check("R10 R2 div 511 taken", 64'(v), 64'(stat_word(511, 0, 1)));

        // Directed frames
        txn(1, 0, 0, 5, 5'h11, 5'h02, 16'hBEEF, 16'h0, 0, 0);  // R4
        txn(2, 0, 0, 6, 5'h1F, 5'h00, 16'h0, 16'h8001, 1, 0);  // R5 R7 bad TA
        txn(2, 0, 0, 5, 5'h00, 5'h1F, 16'h0, 16'h7FFE, 0, 1);  // R7 cleared
        txn(0, 1, 0, 5, 5'h03, 5'h07, 16'hC0DE, 16'h0, 0, 0);  // R6
        txn(1, 1, 1, 7, 5'h03, 5'h07, 16'h1234, 16'h0, 0, 1);  // R6 R8
        txn(2, 1, 1, 5, 5'h0A, 5'h15, 16'h0, 16'hA55A, 0, 0);  // R6 R8

        // R6: Clause 22 address write stores only
        wr(6'h30, stat_word(5, 0, 0));
        rises = 0;
        wr(6'h3C, 32'h0000_4321);
        repeat (40) @(negedge clk);
        #1;
        check("R6 C22 address no frame busy", 64'(bus_rdata[0]), 64'h0);
        check("R6 C22 address no mdc", 64'(rises), 64'h0);
        rd(6'h3C, v); check("R6 C22 address stored", 64'(v), 64'h4321);

        // R9: writes during busy ignored
        wr(6'h34, (32'd3 << 5) | 32'd4);
        rises = 0; phy_pos = 0;
        wr(6'h38, 32'h0000_A5A5);
        wr(6'h34, 32'h0000_83FF);
        wr(6'h38, 32'h0000_1111);
        wr(6'h3C, 32'h0000_2222);
        wr(6'h30, stat_word(9, 1, 1));
        wait_idle(cyc);
        check("R9 one frame only", 64'(rises), 64'd64);
        rd(6'h34, v); check("R9 control kept", 64'(v), 64'((32'd3 << 5) | 32'd4));
        rd(6'h38, v); check("R9 data kept", 64'(v), 64'hA5A5);
        rd(6'h3C, v); check("R9 address kept", 64'(v), 64'h4321);
        rd(6'h30, v); check("R9 status kept", 64'(v), 64'(stat_word(5, 0, 0)));

        // Random transactions
        for (int i = 0; i < 24; i++) begin
            int k;
            k = int'($urandom % 5);
            txn((k == 0 || k == 3) ? 1 : (k == 2) ? 0 : 2, (k >= 2), bit'($urandom % 2),
                5 + int'($urandom % 3), 5'($urandom), 5'($urandom), 16'($urandom),
                16'($urandom), ($urandom % 4) == 0, bit'($urandom % 2));
        end

        check("R11 line stable while mdc high", 64'(hold_viol), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule